// File: doc/BRIEF.md
# Table-Programmed Quad Serial Flash Read Sequencer

This block reads bytes from a serial NOR flash. A small table holds short bus programs. Each program is a list of 16-bit instructions: send an opcode byte, shift out the address, idle for dummy clocks, or capture read data. Every instruction names its own pad width, either one data line or four. As a result, the same engine can run a plain single-line fast read or a quad-I/O read, and only the table contents differ.

Software first loads the table. It then sets a 24-bit flash address, a byte count and a program index, clears the receive FIFO and pulses the trigger. The sequencer holds chip select low for the whole program and toggles an SDR serial clock at half the system clock rate. It packs captured bits into bytes and pushes them into a receive FIFO. At the end it releases chip select and raises a completion flag. The address shifted onto the bus is loaded fresh from the address input at every trigger, so one transfer never depends on the one before it.

Top module: `qspi_seq_reader`

## Requirements
- R1: A program of opcode 0xEB on one line, a 24-bit address on four lines (most significant nibble first, on `ioOut[3:0]`), 6 dummy clocks and data on four lines produces exactly 20 + 2·N serial clocks for N bytes. The data is captured high nibble first from `ioIn[3:0]`, and the output enables are 4'b0001 during the opcode, 4'hF during the address and 0 afterwards.
- R2: A single-line program drives `ioOut[0]` only. It sends the opcode and the 24-bit address MSB first, waits 8 dummy clocks and captures data MSB first from `ioIn[1]`, for 40 + 8·N serial clocks in total.
- R3: Each 32-bit table word holds two instructions, the lower half first. An instruction packs the operand in [7:0], the pad code in [9:8] (0 = one line, 2 = four lines) and the opcode in [15:10] (1 = opcode byte, 2 = address with the operand giving the bit count, 12 = dummy with the operand giving clocks, 9 = read, 0 = stop). A program ends at the first stop instruction or after its last slot. Table word k of program s is written at table address 2·s + k.
- R4: No bus activity begins until `trigger` is pulsed. Until then chip select stays high and the serial clock stays low.
- R5: The address shifted out always equals `cmdAddr` as sampled at the trigger, whatever the previous transfer was. This includes a 1-byte read at an address ending in 0x3 that immediately follows a 1-byte read at an address ending in 0x2.
- R6: A read instruction captures exactly `cmdLen` bytes, even when its operand differs. A length of 1 is allowed.
- R7: `doneFlag` rises when a program finishes and is cleared by a pulse on `doneClr`. If a clear arrives in the same cycle as completion, the flag ends up set.
- R8: The receive FIFO returns bytes in arrival order through `rxData`/`rxPop`, and a pulse on `rxClr` empties it.
- R9: A trigger while a transfer is running is ignored and sets `errFlag`. An unknown opcode ends the program and sets `errFlag` as well as `doneFlag`. A pulse on `errClr` clears `errFlag`.
- R10: Chip select falls once per transfer and stays low with no gap until the program ends. The serial clock is low whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| lutWe | input | 1 | Table word write strobe |
| lutAddr | input | 3 | Table word address (2·program + word) |
| lutWdata | input | 32 | Table word, two instructions |
| cmdAddr | input | 24 | Flash byte address |
| cmdLen | input | 8 | Bytes to read |
| cmdSeq | input | 2 | Program index |
| trigger | input | 1 | Start pulse |
| rxClr | input | 1 | Empty the receive FIFO |
| rxPop | input | 1 | Remove the head byte |
| rxData | output | 8 | Head byte of the receive FIFO |
| rxEmpty | output | 1 | Receive FIFO empty |
| rxLevel | output | 4 | Bytes held |
| doneClr | input | 1 | Clear the completion flag |
| errClr | input | 1 | Clear the error flag |
| doneFlag | output | 1 | Program finished |
| errFlag | output | 1 | Busy trigger or bad opcode seen |
| sck | output | 1 | Serial clock |
| csN | output | 1 | Chip select, active low |
| ioOut | output | 4 | Data lines out |
| ioOe | output | 4 | Per-line output enable |
| ioIn | input | 4 | Data lines in |

## Verification
Completion of a program and the software clear of the completion flag can land in the same clock cycle. The bench provokes this by watching for chip select to return high, which marks the final state, and pulsing `doneClr` before the next edge. It then requires the flag to read high. A later clear on its own must still bring the flag back to zero.

// File: rtl/qsr_pkg.sv
package qsr_pkg;

  localparam logic [5:0] OPC_STOP  = 6'd0;
  localparam logic [5:0] OPC_CMD   = 6'd1;
  localparam logic [5:0] OPC_ADDR  = 6'd2;
  localparam logic [5:0] OPC_READ  = 6'd9;
  localparam logic [5:0] OPC_DUMMY = 6'd12;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_LOW,
    ST_HIGH,
    ST_FINISH
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latch;     // take a new address
    logic loadOp;    // load opcode byte into the tx shifter
    logic loadAddr;  // load address into the tx shifter
    logic shift;     // advance tx shifter by one bus clock
    logic capture;   // sample ioIn into the rx shifter
    logic push;      // this capture completes a byte
    logic quad;      // current instruction uses four lines
    logic drive;     // enable outputs
  } dpStrobe_t;

endpackage

// File: rtl/qsr_rx_fifo.sv
module qsr_rx_fifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       clr,
  input  logic                       push,
  input  logic [WIDTH-1:0]           pushData,
  input  logic                       pop,
  output logic [WIDTH-1:0]           headData,
  output logic                       empty,
  output logic [$clog2(DEPTH):0]     level
);
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW:0]      wrPtr, rdPtr;
  logic             full;

  assign level    = wrPtr - rdPtr;
  assign empty    = (level == '0);
  assign full     = (level == (AW+1)'(DEPTH));
  assign headData = mem[rdPtr[AW-1:0]];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else if (clr) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (push && !full) wrPtr <= wrPtr + 1'b1;
      if (pop && !empty) rdPtr <= rdPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full && !clr) mem[wrPtr[AW-1:0]] <= pushData;
  end

  assert_clr_empties_R8: assert property (@(posedge clk) disable iff (!rstN)
    clr |=> empty);

  assert_level_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    level <= (AW+1)'(DEPTH));

endmodule

// File: rtl/qsr_datapath.sv
module qsr_datapath
  import qsr_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [7:0]        operand,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [3:0]        ioIn,
  output logic [3:0]        ioOut,
  output logic [3:0]        ioOe,
  output logic              pushEn,
  output logic [7:0]        pushData
);
  localparam int TX_W = ADDR_W + 8;

  logic [ADDR_W-1:0] addrReg;
  logic [TX_W-1:0]   txSh;
  logic [7:0]        rxSh, rxNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) addrReg <= '0;
    else if (strb.latch) addrReg <= cmdAddr;
  end

  // the address is always reloaded from addrReg; no leftover bits survive
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) txSh <= '0;
    else if (strb.loadOp) txSh <= {operand, {ADDR_W{1'b0}}};
    else if (strb.loadAddr) txSh <= {addrReg, 8'h00};
    else if (strb.shift) txSh <= strb.quad ? {txSh[TX_W-5:0], 4'h0}
                                           : {txSh[TX_W-2:0], 1'b0};
  end

  assign ioOut = strb.quad ? txSh[TX_W-1 -: 4] : {3'b000, txSh[TX_W-1]};

  for (genvar g = 0; g < 4; g++) begin : g_lane
    if (g == 0) begin : g_base
      assign ioOe[g] = strb.drive;
    end else begin : g_wide
      assign ioOe[g] = strb.drive && strb.quad;
    end
  end

  assign rxNext = strb.quad ? {rxSh[3:0], ioIn} : {rxSh[6:0], ioIn[1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxSh <= '0;
    else if (strb.capture) rxSh <= rxNext;
  end

  assign pushEn   = strb.capture && strb.push;
  assign pushData = rxNext;

  assert_addr_fresh_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadAddr |=> (txSh[TX_W-1 -: ADDR_W] == addrReg));

endmodule

// File: rtl/qsr_ctrl.sv
module qsr_ctrl
  import qsr_pkg::*;
#(
  parameter int NUM_SEQ       = 4,
  parameter int INSTR_PER_SEQ = 4,   // power of two
  parameter int LEN_W         = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          lutWe,
  input  logic [$clog2(NUM_SEQ*INSTR_PER_SEQ/2)-1:0] lutAddr,
  input  logic [31:0]                   lutWdata,
  input  logic                          trigger,
  input  logic [$clog2(NUM_SEQ)-1:0]    cmdSeq,
  input  logic [LEN_W-1:0]              cmdLen,
  input  logic                          doneClr,
  input  logic                          errClr,
  output dpStrobe_t                     strb,
  output logic [7:0]                    operand,
  output logic                          sck,
  output logic                          csN,
  output logic                          doneFlag,
  output logic                          errFlag
);
  localparam int SEQ_W  = $clog2(NUM_SEQ);
  localparam int PTR_W  = $clog2(INSTR_PER_SEQ);
  localparam int LUT_N  = NUM_SEQ * INSTR_PER_SEQ;
  localparam int LUT_AW = $clog2(LUT_N / 2);
  localparam int CNT_W  = LEN_W + 4;
  localparam logic [PTR_W:0] PTR_END = (PTR_W+1)'(INSTR_PER_SEQ);

  logic [15:0]       lut [LUT_N];
  seqState_e         state;
  logic [SEQ_W-1:0]  seqReg;
  logic [LEN_W-1:0]  lenReg;
  logic [PTR_W:0]    ptr;
  logic [5:0]        curOp;
  logic              curQuad;
  logic [CNT_W-1:0]  clkLeft;
  logic [2:0]        subCnt;
  logic [LEN_W-1:0]  bytesDone;

  logic [15:0]       instr;
  logic [5:0]        opc;
  logic              padQuad;
  logic              slotValid;
  logic              opKnown;
  logic [CNT_W-1:0]  fetchClocks;
  logic              errSet;
  logic              isShiftOp;

  // table write: two instructions per word, lower half first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < LUT_N; i++) lut[i] <= '0;
    end else if (lutWe) begin
      for (int i = 0; i < LUT_N; i++) begin
        if (lutAddr == LUT_AW'(i / 2))
          lut[i] <= (i % 2 == 1) ? lutWdata[31:16] : lutWdata[15:0];
      end
    end
  end

  // decode of the instruction under the pointer
  assign instr     = lut[{seqReg, ptr[PTR_W-1:0]}];
  assign opc       = instr[15:10];
  assign padQuad   = instr[9];
  assign operand   = instr[7:0];
  assign slotValid = (ptr != PTR_END);
  assign opKnown   = (opc == OPC_STOP) || (opc == OPC_CMD) || (opc == OPC_ADDR) ||
                     (opc == OPC_DUMMY) || (opc == OPC_READ);

  always_comb begin
    fetchClocks = '0;
    case (opc)
      OPC_CMD:   fetchClocks = padQuad ? CNT_W'(2) : CNT_W'(8);
      OPC_ADDR:  fetchClocks = padQuad ? CNT_W'(operand >> 2) : CNT_W'(operand);
      OPC_DUMMY: fetchClocks = CNT_W'(operand);
      OPC_READ:  fetchClocks = padQuad ? CNT_W'({lenReg, 1'b0}) : CNT_W'({lenReg, 3'b000});
      default:   fetchClocks = '0;
    endcase
  end

  assign isShiftOp = (curOp == OPC_CMD) || (curOp == OPC_ADDR);

  always_comb begin
    strb          = '0;
    strb.latch    = (state == ST_IDLE) && trigger;
    strb.loadOp   = (state == ST_FETCH) && slotValid && (opc == OPC_CMD);
    strb.loadAddr = (state == ST_FETCH) && slotValid && (opc == OPC_ADDR);
    strb.shift    = (state == ST_HIGH) && isShiftOp;
    strb.capture  = (state == ST_HIGH) && (curOp == OPC_READ);
    strb.push     = strb.capture && (curQuad ? subCnt[0] : (subCnt == 3'd7));
    strb.quad     = curQuad;
    strb.drive    = ((state == ST_LOW) || (state == ST_HIGH)) && isShiftOp;
  end

  assign errSet = (trigger && (state != ST_IDLE)) ||
                  ((state == ST_FETCH) && slotValid && !opKnown);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      seqReg  <= '0;
      lenReg  <= '0;
      ptr     <= '0;
      curOp   <= OPC_STOP;
      curQuad <= 1'b0;
      clkLeft <= '0;
      subCnt  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (trigger) begin
          seqReg <= cmdSeq;
          lenReg <= cmdLen;
          ptr    <= '0;
          state  <= ST_FETCH;
        end
        ST_FETCH: begin
          subCnt <= '0;
          if (!slotValid || (opc == OPC_STOP) || !opKnown) begin
            curOp <= OPC_STOP;
            state <= ST_FINISH;
          end else begin
            ptr     <= ptr + 1'b1;
            curOp   <= opc;
            curQuad <= padQuad;
            clkLeft <= fetchClocks;
            if (fetchClocks != '0) state <= ST_LOW;
          end
        end
        ST_LOW: state <= ST_HIGH;
        ST_HIGH: begin
          clkLeft <= clkLeft - 1'b1;
          subCnt  <= strb.push ? 3'd0 : subCnt + 3'd1;
          if (clkLeft == CNT_W'(1)) begin
            curOp <= OPC_STOP;
            state <= ST_FETCH;
          end else begin
            state <= ST_LOW;
          end
        end
        ST_FINISH: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneFlag <= 1'b0;
      errFlag  <= 1'b0;
    end else begin
      if (state == ST_FINISH) doneFlag <= 1'b1;
      else if (doneClr)       doneFlag <= 1'b0;
      if (errSet)             errFlag  <= 1'b1;
      else if (errClr)        errFlag  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bytesDone <= '0;
    else if (strb.latch) bytesDone <= '0;
    else if (strb.push) bytesDone <= bytesDone + 1'b1;
  end

  assign csN = !((state == ST_FETCH) || (state == ST_LOW) || (state == ST_HIGH));
  assign sck = (state == ST_HIGH);

  assert_len_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |-> (bytesDone < lenReg));

  assert_done_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FINISH) |=> doneFlag);

  assert_busy_trigger_R9: assert property (@(posedge clk) disable iff (!rstN)
    (trigger && !csN) |=> (errFlag && $stable(seqReg)));

  assert_sck_in_cs_R10: assert property (@(posedge clk) disable iff (!rstN)
    sck |-> !csN);

  assert_no_idle_start_R4: assert property (@(posedge clk) disable iff (!rstN)
    (csN && !trigger && state != ST_FINISH) |=> csN);

endmodule

// File: rtl/qspi_seq_reader.sv
module qspi_seq_reader
  import qsr_pkg::*;
#(
  parameter int ADDR_W        = 24,
  parameter int LEN_W         = 8,
  parameter int NUM_SEQ       = 4,
  parameter int INSTR_PER_SEQ = 4,
  parameter int FIFO_DEPTH    = 8,
  localparam int SEQ_W        = $clog2(NUM_SEQ),
  localparam int LUT_AW       = $clog2(NUM_SEQ*INSTR_PER_SEQ/2),
  localparam int LVL_W        = $clog2(FIFO_DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lutWe,
  input  logic [LUT_AW-1:0] lutAddr,
  input  logic [31:0]       lutWdata,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [LEN_W-1:0]  cmdLen,
  input  logic [SEQ_W-1:0]  cmdSeq,
  input  logic              trigger,
  input  logic              rxClr,
  input  logic              rxPop,
  output logic [7:0]        rxData,
  output logic              rxEmpty,
  output logic [LVL_W-1:0]  rxLevel,
  input  logic              doneClr,
  input  logic              errClr,
  output logic              doneFlag,
  output logic              errFlag,
  output logic              sck,
  output logic              csN,
  output logic [3:0]        ioOut,
  output logic [3:0]        ioOe,
  input  logic [3:0]        ioIn
);
  dpStrobe_t  strb;
  logic [7:0] operand;
  logic       pushEn;
  logic [7:0] pushData;

  qsr_ctrl #(
    .NUM_SEQ(NUM_SEQ), .INSTR_PER_SEQ(INSTR_PER_SEQ), .LEN_W(LEN_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .lutWe(lutWe), .lutAddr(lutAddr), .lutWdata(lutWdata),
    .trigger(trigger), .cmdSeq(cmdSeq), .cmdLen(cmdLen), .doneClr(doneClr),
    .errClr(errClr), .strb(strb), .operand(operand), .sck(sck), .csN(csN),
    .doneFlag(doneFlag), .errFlag(errFlag)
  );

  qsr_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .operand(operand), .cmdAddr(cmdAddr),
    .ioIn(ioIn), .ioOut(ioOut), .ioOe(ioOe), .pushEn(pushEn), .pushData(pushData)
  );

  qsr_rx_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_fifo (
    .clk(clk), .rstN(rstN), .clr(rxClr), .push(pushEn), .pushData(pushData),
    .pop(rxPop), .headData(rxData), .empty(rxEmpty), .level(rxLevel)
  );

endmodule

// File: tb/tb_qspi_seq_reader.sv
module tb_qspi_seq_reader;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lutWe = 1'b0;
  logic [2:0] lutAddr = '0;
  logic [31:0] lutWdata = '0;
  logic [23:0] cmdAddr = '0;
  logic [7:0] cmdLen = '0;
  logic [1:0] cmdSeq = '0;
  logic trigger = 1'b0, rxClr = 1'b0, rxPop = 1'b0, doneClr = 1'b0, errClr = 1'b0;
  logic [7:0] rxData;
  logic rxEmpty, doneFlag, errFlag, sck, csN;
  logic [3:0] rxLevel, ioOut, ioOe;
  logic [3:0] ioIn = '0;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  qspi_seq_reader dut (
    .clk(clk), .rstN(rstN), .lutWe(lutWe), .lutAddr(lutAddr), .lutWdata(lutWdata),
    .cmdAddr(cmdAddr), .cmdLen(cmdLen), .cmdSeq(cmdSeq), .trigger(trigger),
    .rxClr(rxClr), .rxPop(rxPop), .rxData(rxData), .rxEmpty(rxEmpty), .rxLevel(rxLevel),
    .doneClr(doneClr), .errClr(errClr), .doneFlag(doneFlag), .errFlag(errFlag),
    .sck(sck), .csN(csN), .ioOut(ioOut), .ioOe(ioOe), .ioIn(ioIn)
  );

  function automatic logic [7:0] memByte(input logic [23:0] a);
    return {a[3:0], a[7:4]} ^ a[15:8] ^ (a[23:16] + 8'h3C) ^ 8'hA5;
  endfunction

  // ---------------- behavioural flash ----------------
  int edgeCnt = 0;
  int csFalls = 0;
  int sckTotal = 0;
  logic [7:0] mCmd = '0;
  logic [23:0] mAddr = '0;
  logic [23:0] seenAddr = '0;
  bit oeBad = 1'b0;

  always @(negedge csN) begin
    edgeCnt = 0; mCmd = '0; mAddr = '0; csFalls++;
  end

  always @(posedge sck) begin
    sckTotal++;
    if (!csN) begin
      if (edgeCnt < 8) begin
        mCmd = {mCmd[6:0], ioOut[0]};
        if (ioOe != 4'h1) oeBad = 1'b1;
      end else if (mCmd == 8'hEB && edgeCnt < 14) begin
        mAddr = {mAddr[19:0], ioOut};
        if (ioOe != 4'hF) oeBad = 1'b1;
        if (edgeCnt == 13) seenAddr = mAddr;
      end else if (mCmd != 8'hEB && edgeCnt < 32) begin
        mAddr = {mAddr[22:0], ioOut[0]};
        if (ioOe != 4'h1) oeBad = 1'b1;
        if (edgeCnt == 31) seenAddr = mAddr;
      end else if (ioOe != 4'h0) begin
        oeBad = 1'b1;
      end
      edgeCnt++;
    end
  end

  always @(negedge sck) begin
    if (!csN) begin
      if (mCmd == 8'hEB && edgeCnt >= 20) begin
        int n;
        logic [7:0] b;
        n = edgeCnt - 20;
        b = memByte(mAddr + 24'(n / 2));
        ioIn = (n % 2 == 0) ? b[7:4] : b[3:0];
      end else if (mCmd != 8'hEB && edgeCnt >= 40) begin
        int n;
        logic [7:0] b;
        n = edgeCnt - 40;
        b = memByte(mAddr + 24'(n / 8));
        ioIn = {2'b00, b[7 - (n % 8)], 1'b0};
      end
    end
  end

  // ---------------- checking helpers ----------------
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic writeLut(input int idx, input logic [31:0] w);
    @(negedge clk);
    lutWe = 1'b1; lutAddr = 3'(idx); lutWdata = w;
    @(negedge clk);
    lutWe = 1'b0;
  endtask

  task automatic pulseDoneClr();
    doneClr = 1'b1; @(negedge clk); doneClr = 1'b0;
  endtask

  // run one transfer and check it; collide = clear done in the completion cycle
  task automatic runRead(input int seq, input logic [23:0] a, input int len,
                         input bit doPop, input bit collide, input string req);
    int startFalls;
    int expEdges;
    bit finished;
    @(negedge clk);
    cmdSeq = 2'(seq); cmdAddr = a; cmdLen = 8'(len);
    rxClr = 1'b1;
    @(negedge clk);
    rxClr = 1'b0;
    startFalls = csFalls;
    oeBad = 1'b0;
    trigger = 1'b1;
    @(negedge clk);
    trigger = 1'b0;
    finished = 1'b0;
    for (int w = 0; w < 4000 && !finished; w++) begin
      if (csN) finished = 1'b1;
      else @(negedge clk);
    end
    if (collide) pulseDoneClr();
    else @(negedge clk);
    chk({req, " R7 done after program"}, {31'b0, doneFlag}, 32'd1);
    chk({req, " R10 single chip-select window"}, csFalls - startFalls, 32'd1);
    if (seq == 0 || seq == 1) begin
      expEdges = (seq == 0) ? 20 + 2 * len : 40 + 8 * len;
      chk({req, seq == 0 ? " R1 quad clock count" : " R2 single clock count"}, edgeCnt, expEdges);
      chk({req, seq == 0 ? " R1 output enables" : " R2 output enables"}, {31'b0, oeBad}, 32'd0);
      chk({req, " R5 address on bus"}, {8'b0, seenAddr}, {8'b0, a});
      chk({req, " R6 byte count"}, {28'b0, rxLevel}, len);
      if (doPop) begin
        for (int k = 0; k < len; k++) begin
          chk({req, " R8 data order"}, {24'b0, rxData}, {24'b0, memByte(a + 24'(k))});
          rxPop = 1'b1; @(negedge clk); rxPop = 1'b0;
        end
        chk({req, " R8 empty after pops"}, {31'b0, rxEmpty}, 32'd1);
      end
    end
    if (!collide) pulseDoneClr();
  endtask

  // ---------------- main ----------------
  initial begin
    int unsigned seed;
    seed = $urandom(32'h5EED);
    repeat (4) @(negedge clk);
    chk("R4 reset csN", {31'b0, csN}, 32'd1);
    chk("R10 reset sck low", {31'b0, sck}, 32'd0);
    chk("R7 reset done", {31'b0, doneFlag}, 32'd0);
    chk("R9 reset err", {31'b0, errFlag}, 32'd0);
    chk("R8 reset empty", {31'b0, rxEmpty}, 32'd1);
    chk("R1 reset oe", {28'b0, ioOe}, 32'd0);
    rstN = 1'b1;

    // R3: program 0 quad, program 1 single, program 2 stops after address,
    // program 3 holds an unknown opcode in slot 1
    writeLut(0, 32'h0A1804EB);
    writeLut(1, 32'h26043206);
    writeLut(2, 32'h0818040B);
    writeLut(3, 32'h24043008);
    writeLut(4, 32'h0A1804EB);
    writeLut(5, 32'h00000000);
    writeLut(6, 32'h140004EB);
    writeLut(7, 32'h00000000);

    // R4: inputs set but no trigger
    cmdAddr = 24'h123456; cmdLen = 8'd2; cmdSeq = 2'd0;
    repeat (50) @(negedge clk);
    chk("R4 no clocks without trigger", sckTotal, 32'd0);
    chk("R4 csN idle high", {31'b0, csN}, 32'd1);

    // R5 directed: address ending 2 then 3, 1-byte reads, quad and single
    runRead(0, 24'hC00002, 1, 1'b1, 1'b0, "R5 quad ..02");
    runRead(0, 24'hC00003, 1, 1'b1, 1'b0, "R5 quad ..03 after ..02");
    runRead(0, 24'hC00003, 1, 1'b1, 1'b0, "R5 quad ..03 repeat");
    runRead(1, 24'h4000F2, 1, 1'b1, 1'b0, "R5 single ..F2");
    runRead(1, 24'h4000F3, 1, 1'b1, 1'b0, "R5 single ..F3 after ..F2");

    // R6: read length above the instruction operand of 4
    runRead(0, 24'hFFFFFA, 8, 1'b1, 1'b0, "R6 quad len 8");
    runRead(1, 24'h000000, 6, 1'b1, 1'b0, "R6 single len 6");

    // R7: clear in the completion cycle, set must win
    runRead(0, 24'h0A0B0C, 2, 1'b1, 1'b1, "R7 collide");
    chk("R7 set wins over clear", {31'b0, doneFlag}, 32'd1);
    pulseDoneClr();
    chk("R7 clear alone", {31'b0, doneFlag}, 32'd0);

    // R8: clear a filled FIFO
    runRead(0, 24'h777770, 3, 1'b0, 1'b0, "R8 fill");
    @(negedge clk); rxClr = 1'b1; @(negedge clk); rxClr = 1'b0;
    chk("R8 clear empties", {31'b0, rxEmpty}, 32'd1);
    chk("R8 level zero", {28'b0, rxLevel}, 32'd0);

    // R3: program ending early at an all-zero instruction
    runRead(2, 24'h345678, 4, 1'b0, 1'b0, "R3 early stop");
    chk("R3 early stop clocks", edgeCnt, 32'd14);
    chk("R3 early stop address", {8'b0, seenAddr}, 32'h345678);
    chk("R3 early stop no data", {31'b0, rxEmpty}, 32'd1);
    chk("R9 no error on stop", {31'b0, errFlag}, 32'd0);

    // R9: unknown opcode
    runRead(3, 24'h000001, 1, 1'b0, 1'b0, "R9 bad opcode");
    chk("R9 bad opcode clocks", edgeCnt, 32'd8);
    chk("R9 bad opcode err", {31'b0, errFlag}, 32'd1);
    @(negedge clk); errClr = 1'b1; @(negedge clk); errClr = 1'b0;
    chk("R9 err cleared", {31'b0, errFlag}, 32'd0);

    // R9: trigger while busy is ignored
    @(negedge clk);
    cmdSeq = 2'd0; cmdAddr = 24'h202020; cmdLen = 8'd2;
    trigger = 1'b1; @(negedge clk); trigger = 1'b0;
    repeat (10) @(negedge clk);
    cmdAddr = 24'h999999; cmdSeq = 2'd1;
    trigger = 1'b1; @(negedge clk); trigger = 1'b0;
    for (int w = 0; w < 4000 && !doneFlag; w++) @(negedge clk);
    chk("R9 busy trigger flags error", {31'b0, errFlag}, 32'd1);
    chk("R9 busy trigger ignored addr", {8'b0, seenAddr}, 32'h202020);
    chk("R9 busy trigger ignored data", {24'b0, rxData}, {24'b0, memByte(24'h202020)});
    chk("R9 busy trigger clocks", edgeCnt, 32'd24);
    pulseDoneClr();
    @(negedge clk); errClr = 1'b1; @(negedge clk); errClr = 1'b0;
    @(negedge clk); rxClr = 1'b1; @(negedge clk); rxClr = 1'b0;

    // random transfers
    for (int t = 0; t < 24; t++) begin
      int seq;
      int len;
      logic [23:0] a;
      seq = int'($urandom % 2);
      len = 1 + int'($urandom % 8);
      a = 24'($urandom);
      runRead(seq, a, len, 1'b1, 1'b0, seq == 0 ? "R1 random quad" : "R2 random single");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule